// File: doc/BRIEF.md
# Page-Mode Parallel ROM Read Controller

This block turns single read requests from an on-chip host into access cycles on an external asynchronous parallel ROM. The ROM can be read 32 bits at a time (double-word mode) or 16 bits at a time (word mode). In word mode the least significant word address bit goes out on the top data line, which then serves as an address input. The controller drives the ROM address, the active-low chip and output enables and the width select. It holds them for a wait count in clock cycles and then captures the data bus. It returns the result with a one-cycle valid pulse.

The ROM answers much sooner when only the in-page address bits change, so the controller remembers which page is open. A page is the same slice of ROM address lines in both modes: eight double words, or sixteen words. A request to the open page, in the mode already selected, uses the short page wait. Any other request uses the long random-access wait. A width change first floats the shared data line for a turnaround time. A long quiet spell drops the ROM into standby, and that closes the page.

Top module: `prom_rd_ctrl`

## Requirements
- R1: During and right after reset: `req_ready`=1, `rsp_valid`=0, `rom_ce_n`=1, `rom_oe_n`=1, `rom_lsb_en`=0. The mode starts as double word (`rom_dw`=1) with no page open.
- R2: A request in the current mode with no page open, or to a different page, produces `rsp_valid` exactly max(T_RAND_CYC, T_OE_CYC) clock edges after the edge that accepts it (20 by default).
- R3: A request in the current mode to the open page produces `rsp_valid` exactly T_PAGE_CYC edges after acceptance (6 by default).
- R4: Address map. With `req_wide`=1, `rom_a`=`req_addr[19:0]` and `req_addr[20]` is ignored. With `req_wide`=0, `rom_a`=`req_addr[20:1]` and `rom_lsb_o`=`req_addr[0]`, with `rom_lsb_en`=1 while the word access runs. In both modes the page is `rom_a[19:3]`.
- R5: `rsp_data` holds all 32 ROM data lines in double-word mode. In word mode it holds lines 15:0, with bits 31:16 forced to zero.
- R6: A request whose `req_wide` differs from the current mode first holds `rom_oe_n`=1 and `rom_lsb_en`=0 for T_TURN_CYC edges, then runs a random access. `rsp_valid` comes T_TURN_CYC + max(T_RAND_CYC, T_OE_CYC) edges after acceptance (24 by default). The shared line is driven only in word mode.
- R7: After IDLE_CYC consecutive idle edges with no request while enabled, `rom_ce_n` and `rom_oe_n` go to 1. The next request is a random access. The output enable is never low while the chip enable is high.
- R8: Only one request is outstanding. `req_ready` is 0 from the edge after acceptance until the edge that raises `rsp_valid`.
- R9: `rsp_valid` lasts one cycle. `rom_a` and `rom_dw` do not change while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 21 | Word address (double-word index in bits 19:0 when wide) |
| req_wide | input | 1 | 1 = 32-bit read, 0 = 16-bit read |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` valid |
| rsp_data | output | 32 | Captured read data |
| rom_a | output | 20 | ROM address lines |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_dw | output | 1 | ROM width select, 1 = double word |
| rom_lsb_o | output | 1 | Word-mode LSB address value for the shared top data line |
| rom_lsb_en | output | 1 | Drive enable for the shared top data line |
| rom_d_i | input | 32 | ROM data bus as received |

## Verification
Every result is due a fixed number of clock edges after the edge that accepts its request: T_PAGE_CYC for a page hit, the random wait for a miss or after standby, and the turnaround plus the random wait for a mode change. The bench works out which case applies from its own page, mode and idle-gap bookkeeping. It then counts edges from acceptance, sampling at each negative edge, and compares the count with the expected one. The ROM model returns a poison word if the data is sampled even one cycle early. A late response shows up as a wrong count. Standby and the turnaround state are checked at the ports at the negative edge after the transitions that cause them.

// File: rtl/prom_pkg.sv
package prom_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_ACC  = 2'd2
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/prom_addr_map.sv
module prom_addr_map #(
    parameter int ROM_AW    = 20,
    parameter int PAGE_BITS = 3,
    localparam int REQ_AW   = ROM_AW + 1,
    localparam int PAGE_W   = ROM_AW - PAGE_BITS
) (
    input  logic [REQ_AW-1:0] req_addr,
    input  logic              wide,
    output logic [ROM_AW-1:0] rom_a,
    output logic              lsb,
    output logic [PAGE_W-1:0] page
);
    timeunit 1ns;
    timeprecision 1ps;

    // Word mode shifts the request by one; the dropped bit travels on the shared line.
    always_comb begin
        if (wide) begin
            rom_a = req_addr[ROM_AW-1:0];
            lsb   = 1'b0;
        end else begin
            rom_a = req_addr[REQ_AW-1:1];
            lsb   = req_addr[0];
        end
        page = rom_a[ROM_AW-1:PAGE_BITS];
    end
endmodule

// File: rtl/prom_page_track.sv
module prom_page_track #(
    parameter int PAGE_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              update,
    input  logic [PAGE_W-1:0] upd_page,
    input  logic [PAGE_W-1:0] cmp_page,
    output logic              hit
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic              open;
        logic [PAGE_W-1:0] page;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (clear) begin
            trk_d.open = 1'b0;
        end else if (update) begin
            trk_d.open = 1'b1;
            trk_d.page = upd_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign hit = trk_q.open && (trk_q.page == cmp_page);
endmodule

// File: rtl/prom_wait_cnt.sv
module prom_wait_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Fires on the edge that completes a loaded count of N.
    assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl #(
    parameter int ROM_AW     = 20,
    parameter int PAGE_BITS  = 3,
    parameter int DATA_W     = 32,
    parameter int T_RAND_CYC = 20,
    parameter int T_PAGE_CYC = 6,
    parameter int T_OE_CYC   = 6,
    parameter int T_TURN_CYC = 4,
    parameter int IDLE_CYC   = 24,
    localparam int REQ_AW    = ROM_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REQ_AW-1:0] req_addr,
    input  logic              req_wide,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ROM_AW-1:0] rom_a,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_dw,
    output logic              rom_lsb_o,
    output logic              rom_lsb_en,
    input  logic [DATA_W-1:0] rom_d_i
);
    timeunit 1ns;
    timeprecision 1ps;
    import prom_pkg::*;

    localparam int PAGE_W = ROM_AW - PAGE_BITS;
    localparam int HALF_W = DATA_W / 2;
    localparam int N_RAND = imax(T_RAND_CYC, T_OE_CYC);
    localparam int N_MAX  = imax(imax(N_RAND, T_PAGE_CYC), T_TURN_CYC);
    localparam int CNT_W  = $clog2(N_MAX + 1);
    localparam int IDLE_W = $clog2(IDLE_CYC + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ROM_AW-1:0] rom_a;
        logic              lsb;
        logic              dw;
        logic              ce_n;
        logic              oe_n;
        logic              lsb_en;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic [IDLE_W-1:0] idle;
    } ctrl_t;

    ctrl_t q, d;

    logic [ROM_AW-1:0] map_a;
    logic              map_lsb;
    logic [PAGE_W-1:0] map_page;
    logic              trk_clear;
    logic              trk_upd;
    logic [PAGE_W-1:0] upd_page;
    logic              page_hit;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expire;

    prom_addr_map #(
        .ROM_AW   (ROM_AW),
        .PAGE_BITS(PAGE_BITS)
    ) i_map (
        .req_addr(req_addr),
        .wide    (req_wide),
        .rom_a   (map_a),
        .lsb     (map_lsb),
        .page    (map_page)
    );

    prom_page_track #(
        .PAGE_W(PAGE_W)
    ) i_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (trk_clear),
        .update  (trk_upd),
        .upd_page(upd_page),
        .cmp_page(map_page),
        .hit     (page_hit)
    );

    prom_wait_cnt #(
        .CNT_W(CNT_W)
    ) i_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expire  (tmr_expire)
    );

    // The page opened after a turnaround comes from the held address.
    assign upd_page = (q.state == ST_TURN) ? q.rom_a[ROM_AW-1:PAGE_BITS] : map_page;

    always_comb begin
        d         = q;
        d.rsp_valid = 1'b0;
        trk_clear = 1'b0;
        trk_upd   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;

        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.idle  = '0;
                    d.rom_a = map_a;
                    d.lsb   = map_lsb;
                    d.ce_n  = 1'b0;
                    if (req_wide != q.dw) begin
                        // Float the shared line before either side drives it.
                        d.dw      = req_wide;
                        d.oe_n    = 1'b1;
                        d.lsb_en  = 1'b0;
                        trk_clear = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = CNT_W'(T_TURN_CYC);
                        d.state   = ST_TURN;
                    end else begin
                        d.oe_n   = 1'b0;
                        d.lsb_en = !req_wide;
                        trk_upd  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = page_hit ? CNT_W'(T_PAGE_CYC) : CNT_W'(N_RAND);
                        d.state  = ST_ACC;
                    end
                end else if (!q.ce_n) begin
                    if (q.idle == IDLE_W'(IDLE_CYC - 1)) begin
                        d.ce_n    = 1'b1;
                        d.oe_n    = 1'b1;
                        d.lsb_en  = 1'b0;
                        d.idle    = '0;
                        trk_clear = 1'b1;
                    end else begin
                        d.idle = q.idle + 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (tmr_expire) begin
                    d.oe_n   = 1'b0;
                    d.lsb_en = !q.dw;
                    trk_upd  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(N_RAND);
                    d.state  = ST_ACC;
                end
            end
            ST_ACC: begin
                if (tmr_expire) begin
                    d.rsp_valid = 1'b1;
                    if (q.dw) begin
                        d.rsp_data = rom_d_i;
                    end else begin
                        d.rsp_data = {{(DATA_W - HALF_W){1'b0}}, rom_d_i[HALF_W-1:0]};
                    end
                    d.state = ST_IDLE;
                end
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.dw    <= 1'b1;
            q.ce_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.state == ST_IDLE);
    assign rsp_valid  = q.rsp_valid;
    assign rsp_data   = q.rsp_data;
    assign rom_a      = q.rom_a;
    assign rom_ce_n   = q.ce_n;
    assign rom_oe_n   = q.oe_n;
    assign rom_dw     = q.dw;
    assign rom_lsb_o  = q.lsb;
    assign rom_lsb_en = q.lsb_en;
endmodule

// File: rtl/prom_rd_ctrl_chk.sv
module prom_rd_ctrl_chk #(
    parameter int ROM_AW = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ROM_AW-1:0] rom_a,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic              rom_dw,
    input logic              rom_lsb_en
);
    timeunit 1ns;
    timeprecision 1ps;

    assert_oe_needs_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce_n |-> rom_oe_n);

    assert_standby_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce_n |-> !rom_lsb_en);

    assert_lsb_word_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_lsb_en |-> !rom_dw);

    assert_turn_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rom_dw) |-> (rom_oe_n && !rom_lsb_en));

    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(rom_a) && $stable(rom_dw)));
endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(
    .ROM_AW(ROM_AW)
) i_prom_rd_ctrl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rom_a     (rom_a),
    .rom_ce_n  (rom_ce_n),
    .rom_oe_n  (rom_oe_n),
    .rom_dw    (rom_dw),
    .rom_lsb_en(rom_lsb_en)
);

// File: tb/test_prom_rd_ctrl.sv
module test_prom_rd_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int T_RAND = 20;
    localparam int T_PAGE = 6;
    localparam int T_OE   = 6;
    localparam int T_TURN = 4;
    localparam int IDLE   = 24;
    localparam int N_RAND = (T_RAND > T_OE) ? T_RAND : T_OE;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [20:0] req_addr;
    logic        req_wide;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [19:0] rom_a;
    logic        rom_ce_n, rom_oe_n, rom_dw, rom_lsb_o, rom_lsb_en;
    logic [31:0] rom_d;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    prom_rd_ctrl i_prom_rd_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wide(req_wide),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rom_a(rom_a), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_dw(rom_dw), .rom_lsb_o(rom_lsb_o), .rom_lsb_en(rom_lsb_en),
        .rom_d_i(rom_d)
    );

    function automatic logic [15:0] refw(input logic [20:0] w);
        logic [31:0] h;
        h = {11'h0, w} * 32'h9E37_79B1;
        h = h ^ (h >> 13);
        return h[15:0] ^ h[31:16];
    endfunction

    // Behavioural ROM: stability counters refreshed at each falling edge.
    int rc = 0, pc = 0, oc = 0;
    logic ce_seen = 1'b0, oe_seen = 1'b0;
    logic [17:0] prev_page, pk;
    logic [21:0] prev_full, fk;

    always @(negedge clk) begin
        if (rom_ce_n) begin
            rc <= 0; pc <= 0; oc <= 0; ce_seen <= 1'b0; oe_seen <= 1'b0;
        end else begin
            pk = {rom_dw, rom_a[19:3]};
            fk = {rom_dw, rom_a, rom_dw ? 1'b0 : rom_lsb_o};
            if (!ce_seen || pk != prev_page) rc <= 0; else if (rc < 1000) rc <= rc + 1;
            if (!ce_seen || fk != prev_full) pc <= 0; else if (pc < 1000) pc <= pc + 1;
            if (rom_oe_n) begin oc <= 0; oe_seen <= 1'b0; end
            else if (!oe_seen) begin oc <= 0; oe_seen <= 1'b1; end
            else if (oc < 1000) oc <= oc + 1;
            ce_seen   <= 1'b1;
            prev_page <= pk;
            prev_full <= fk;
        end
    end

    always_comb begin
        if (!rom_ce_n && !rom_oe_n && ce_seen && oe_seen &&
            rc + 1 >= T_RAND && pc + 1 >= T_PAGE && oc + 1 >= T_OE) begin
            if (rom_dw) rom_d = {refw({rom_a, 1'b1}), refw({rom_a, 1'b0})};
            else        rom_d = {16'hFFFF, refw({rom_a, rom_lsb_o})};
        end else begin
            rom_d = 32'hBAD0_BAD0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Bench view of the controller's page state.
    logic        exp_open = 1'b0;
    logic [16:0] exp_page = '0;
    logic        exp_dw   = 1'b1;
    int          idle_base = 0;

    task automatic run_req(input logic [20:0] a, input logic w, input int g);
        logic [16:0] pg;
        int   exp_lat;
        int   lat;
        bit   busy_ok;
        bit   mchg;
        bit   sby;
        string tag;
        logic [31:0] exp_d;
        repeat (g) @(negedge clk);
        sby = (idle_base > 0) && (idle_base + g >= IDLE);
        if (sby) begin
            chk(rom_ce_n && rom_oe_n, "R7 standby", {30'h0, rom_ce_n, rom_oe_n}, 32'h3);
            exp_open = 1'b0;
        end
        chk(req_ready, "R8 ready idle", {31'h0, req_ready}, 32'h1);
        pg   = w ? a[19:3] : a[20:4];
        mchg = (w != exp_dw);
        if (mchg) begin
            exp_lat = T_TURN + N_RAND; tag = "R6 turn latency";
        end else if (exp_open && pg == exp_page) begin
            exp_lat = T_PAGE; tag = "R3 page latency";
        end else begin
            exp_lat = N_RAND; tag = sby ? "R7 post-standby latency" : "R2 random latency";
        end
        exp_open = 1'b1; exp_page = pg; exp_dw = w;
        exp_d = w ? {refw({a[19:0], 1'b1}), refw({a[19:0], 1'b0})} : {16'h0, refw(a)};
        req_addr = a; req_wide = w; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        chk(!req_ready, "R8 busy", {31'h0, req_ready}, 32'h0);
        if (mchg) begin
            chk(rom_oe_n && !rom_lsb_en, "R6 float", {30'h0, rom_oe_n, rom_lsb_en}, 32'h2);
        end else begin
            chk(rom_a == (w ? a[19:0] : a[20:1]), "R4 rom address", {12'h0, rom_a},
                {12'h0, (w ? a[19:0] : a[20:1])});
            if (!w) chk(rom_lsb_en && rom_lsb_o == a[0], "R4 shared lsb",
                        {30'h0, rom_lsb_en, rom_lsb_o}, {30'h0, 1'b1, a[0]});
        end
        lat = 0; busy_ok = 1'b1;
        while (lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (rsp_valid) break;
            if (req_ready) busy_ok = 1'b0;
        end
        chk(lat == exp_lat, tag, lat, exp_lat);
        chk(rsp_data == exp_d, w ? "R5 dword data" : "R5 word data", rsp_data, exp_d);
        chk(busy_ok, "R8 ready low while busy", {31'h0, busy_ok}, 32'h1);
        @(negedge clk);
        chk(!rsp_valid, "R9 single pulse", {31'h0, rsp_valid}, 32'h0);
        idle_base = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R8 act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [20:0] last_a;
        logic        last_w;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_wide = 1'b1;
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !rsp_valid && rom_ce_n && rom_oe_n && !rom_lsb_en && rom_dw, "R1 reset",
            {26'h0, req_ready, rsp_valid, rom_ce_n, rom_oe_n, rom_lsb_en, rom_dw}, 32'h2D);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && rom_ce_n && rom_oe_n, "R1 after release",
            {29'h0, req_ready, rom_ce_n, rom_oe_n}, 32'h7);

        run_req(21'h000000, 1'b0, 0);          // R6: word after reset
        run_req(21'h000001, 1'b0, 0);          // R3
        run_req(21'h00000F, 1'b0, 2);          // R3: last word of page
        run_req(21'h000010, 1'b0, 0);          // R4: next word page
        run_req(21'h000017, 1'b1, 0);          // R6 back to dword
        run_req(21'h100010, 1'b1, 1);          // R4: bit 20 ignored, same page
        run_req(21'h000018, 1'b1, 0);          // R2: next dword page
        run_req(21'h000019, 1'b1, IDLE + 3);   // R7: standby then random
        run_req(21'h1FFFFF, 1'b0, 0);          // R6 + top address
        run_req(21'h1FFFF0, 1'b0, 0);          // R3
        last_a = 21'h1FFFF0; last_w = 1'b0;

        for (int i = 0; i < 400; i++) begin
            logic [20:0] a;
            logic        w;
            int          g;
            w = (($urandom % 8) == 0) ? ~last_w : last_w;
            if ($urandom % 2) a = {last_a[20:4], 4'($urandom)};
            else              a = 21'($urandom);
            g = (($urandom % 12) == 0) ? IDLE + int'($urandom % 4) : int'($urandom % 4);
            run_req(a, w, g);
            last_a = a; last_w = w;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule